// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32.768 kHz timebase down to a periodic interrupt tick. The timebase arrives as a single-cycle clock-enable pulse on the system clock. A 4-bit rate code picks the tick period. An enable bit gates the tick, and a 3-bit divider-control field can hold the divider chain in reset. On each expired period the block raises a one-cycle request to set the periodic flag in the interrupt status register. When the tick is enabled, it also raises a request to set the summary interrupt flag.

A small state machine sits in front of the divider counter. It has three states. `IDLE` means the tick is stopped: the enable is clear or the rate code is 0. `HOLD` means the divider-control field holds the chain in reset. `RUN` means the tick is counting. The next state is always chosen in this order: first HOLD if the hold pattern is present, otherwise RUN if the enable is set and the rate code is non-zero, otherwise IDLE. This gives the named transitions IDLE→RUN (start), RUN→IDLE (stop), any→HOLD (hold), HOLD→RUN (release) and HOLD→IDLE (release while stopped). The counter is cleared in IDLE and in HOLD, and it counts timebase pulses in RUN.

A change of rate code while running does not restart the count. Time elapsed since the last tick is kept and compared against the new period. If that time already reaches the new period, the tick fires on the very next timebase pulse.

Top module: `periodic_tick_gen`

## Requirements
- R1: After reset both flag-set outputs are low, and the first tick after entering RUN comes a full period of timebase pulses later.
- R2: The period in timebase pulses is 128 for rate code 1, 256 for code 2, and 2^(code-1) for codes 3 to 15 (code 3 gives 4 and code 15 gives 16384).
- R3: Rate code 0 stops the tick and clears the elapsed count.
- R4: `pf_set` is a one-clock pulse. It is high in the clock after the clock in which the timebase pulse that completes a period is sampled, and it is never high otherwise.
- R5: `irqf_set` is high exactly when `pf_set` is high and the enable bit is set.
- R6: With the enable bit clear no tick occurs and the elapsed count is cleared, so the first tick after re-enabling comes a full period later.
- R7: While `div_ctrl[2:1]` is 2'b11 the counter is held at zero and no tick occurs. After release the first tick comes a full period later.
- R8: A rate-code change while running keeps the timebase pulses elapsed since the last tick. The next tick comes when the elapsed count reaches the new period.
- R9: If the elapsed count is already at or beyond the new period when the rate changes, the tick fires on the next timebase pulse.
- R10: `div_ctrl` values other than 3'b11x (for example 3'b010, 3'b100, 3'b001) do not affect counting.
- R11: System clocks without a timebase pulse do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_en | input | 1 | 32.768 kHz timebase enable, one system clock wide |
| rate_code | input | 4 | Period select code |
| div_ctrl | input | 3 | Divider-control field; 3'b11x holds the divider |
| pie | input | 1 | Periodic interrupt enable |
| pf_set | output | 1 | Pulse: set the periodic flag |
| irqf_set | output | 1 | Pulse: set the summary interrupt flag |

## Verification
Several short codes (1, 2, 3, 4, 6) and the longest code (15) are run over many periods. This separates a correct period table from an off-by-one or from a swapped pair of the two special codes. Rate changes are made mid-period in both directions, and in one case the elapsed count already exceeds the new period. These cases tell the keep-elapsed rule apart from a restart and from an uncapped carry. Stops by code 0, by a clear enable and by the hold pattern are each followed by a restart, which shows whether the count was really cleared. Runs of idle clocks between pulses, and non-hold divider-control values set mid-run, show that neither one disturbs the count.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        PTG_IDLE = 2'd0,
        PTG_HOLD = 2'd1,
        PTG_RUN  = 2'd2
    } ptg_state_e;

endpackage

// File: rtl/ptg_rate_decode.sv
module ptg_rate_decode #(
    parameter int CODE_W   = 4,
    parameter int CNT_W    = 14,
    parameter int FAST1_SH = 7,
    parameter int FAST2_SH = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W:0]    period,
    output logic              valid
);
    localparam logic [CNT_W:0]    ONE_P  = {{CNT_W{1'b0}}, 1'b1};
    localparam logic [CODE_W-1:0] ONE_C  = {{(CODE_W-1){1'b0}}, 1'b1};
    localparam logic [CODE_W-1:0] TWO_C  = ONE_C << 1;
    localparam logic [CODE_W-1:0] SH1    = FAST1_SH[CODE_W-1:0];
    localparam logic [CODE_W-1:0] SH2    = FAST2_SH[CODE_W-1:0];

    logic [CODE_W-1:0] sh;

    always_comb begin
        valid = (code != '0);
        if (code == ONE_C)      sh = SH1;
        else if (code == TWO_C) sh = SH2;
        else if (code == '0)    sh = '0;
        else                    sh = code - ONE_C;
        period = ONE_P << sh;
    end
endmodule

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
    import ptg_pkg::*;
#(
    parameter int           DIV_W    = 3,
    parameter logic [2:0]   HOLD_MSK = 3'b110,
    parameter logic [2:0]   HOLD_VAL = 3'b110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pie,
    input  logic             rate_ok,
    input  logic [DIV_W-1:0] div_ctrl,
    output ptg_state_e       st,
    output logic             cnt_clr,
    output logic             cnt_run
);
    logic       hold_req;
    logic       run_req;
    ptg_state_e st_nxt;

    assign hold_req = ((div_ctrl & HOLD_MSK) == HOLD_VAL);
    assign run_req  = pie && rate_ok;

    always_comb begin
        st_nxt = st;
        unique case (st)
            PTG_IDLE: begin
                if (hold_req)     st_nxt = PTG_HOLD;   // hold
                else if (run_req) st_nxt = PTG_RUN;    // start
            end
            PTG_HOLD: begin
                if (!hold_req)    st_nxt = run_req ? PTG_RUN : PTG_IDLE; // release
            end
            PTG_RUN: begin
                if (hold_req)     st_nxt = PTG_HOLD;   // hold
                else if (!run_req) st_nxt = PTG_IDLE;  // stop
            end
            default:              st_nxt = PTG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PTG_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        cnt_clr = 1'b1;
        cnt_run = 1'b0;
        unique case (st)
            PTG_IDLE: begin cnt_clr = 1'b1; cnt_run = 1'b0; end
            PTG_HOLD: begin cnt_clr = 1'b1; cnt_run = 1'b0; end
            PTG_RUN:  begin cnt_clr = 1'b0; cnt_run = 1'b1; end
            default:  begin cnt_clr = 1'b1; cnt_run = 1'b0; end
        endcase
    end
endmodule

// File: rtl/ptg_counter.sv
module ptg_counter #(
    parameter int CNT_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic           tb_en,
    input  logic [CNT_W:0] period,
    output logic           fire
);
    localparam logic [CNT_W:0] ONE_P = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W:0]   bumped;

    assign bumped = {1'b0, elapsed} + ONE_P;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (clr) begin
                elapsed <= '0;
            end else if (run && tb_en) begin
                if (bumped >= period) begin
                    elapsed <= '0;
                    fire    <= 1'b1;
                end else begin
                    elapsed <= bumped[CNT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
    import ptg_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int FAST1_SH = 7,
    parameter int FAST2_SH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic [2:0]        div_ctrl,
    input  logic              pie,
    output logic              pf_set,
    output logic              irqf_set
);
    localparam int CNT_W = (1 << CODE_W) - 2;

    logic [CNT_W:0] period;
    logic           rate_ok;
    logic           cnt_clr;
    logic           cnt_run;
    logic           fire;
    ptg_state_e     st;

    ptg_rate_decode #(
        .CODE_W(CODE_W), .CNT_W(CNT_W),
        .FAST1_SH(FAST1_SH), .FAST2_SH(FAST2_SH)
    ) u_dec (
        .code(rate_code), .period(period), .valid(rate_ok)
    );

    ptg_ctrl #(.DIV_W(3)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pie(pie), .rate_ok(rate_ok),
        .div_ctrl(div_ctrl), .st(st), .cnt_clr(cnt_clr), .cnt_run(cnt_run)
    );

    ptg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run),
        .tb_en(tb_en), .period(period), .fire(fire)
    );

    assign pf_set   = fire;
    assign irqf_set = fire && pie;
endmodule

// File: rtl/periodic_tick_gen_chk.sv
module periodic_tick_gen_chk
    import ptg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tb_en,
    input logic       pie,
    input logic       pf_set,
    input logic       irqf_set,
    input ptg_state_e st
);
    // R4
    pf_needs_tb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |-> $past(tb_en));

    // R4
    pf_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |=> !pf_set);

    // R5
    irqf_with_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irqf_set |-> (pf_set && pie));

    // R3
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PTG_IDLE) |=> !pf_set);

    // R7
    hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PTG_HOLD) |=> !pf_set);
endmodule

bind periodic_tick_gen periodic_tick_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .pie(pie),
    .pf_set(pf_set), .irqf_set(irqf_set), .st(st)
);

// File: tb/sim_periodic_tick_gen.sv
module sim_periodic_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic [2:0] div_ctrl = 3'b000;
    logic       pie = 1'b0;
    logic       pf_set;
    logic       irqf_set;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit arm = 1'b0;

    bit    exp_q[$];
    bit    irq_q[$];
    string tag_q[$];

    int m_el = 0;

    always #10 clk = ~clk;

    periodic_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .rate_code(rate_code),
        .div_ctrl(div_ctrl), .pie(pie), .pf_set(pf_set), .irqf_set(irqf_set)
    );

    function automatic int m_period(input logic [3:0] c);
        if (c == 4'd1) return 128;
        if (c == 4'd2) return 256;
        return 1 << (int'(c) - 1);
    endfunction

    function automatic bit m_running();
        return pie && (rate_code != 4'd0) && (div_ctrl[2:1] != 2'b11);
    endfunction

    task automatic set_cfg(input logic [3:0] c, input logic p, input logic [2:0] d);
        @(negedge clk);
        rate_code = c; pie = p; div_ctrl = d;
        if (!m_running()) m_el = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulses(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            bit e;
            @(negedge clk);
            e = 1'b0;
            if (m_running()) begin
                if (m_el + 1 >= m_period(rate_code)) begin e = 1'b1; m_el = 0; end
                else m_el++;
            end
            exp_q.push_back(e);
            irq_q.push_back(e && pie);
            tag_q.push_back(tag);
            tb_en = 1'b1;
            @(negedge clk);
            tb_en = 1'b0;
        end
    endtask

    always @(posedge clk) arm <= tb_en;

    always @(negedge clk) begin
        if (rst_n) begin
            if (arm) begin
                bit e, ei;
                string t;
                e = exp_q.pop_front(); ei = irq_q.pop_front(); t = tag_q.pop_front();
                checks++;
                if (pf_set !== e || irqf_set !== ei) begin
                    errors++;
                    $display("FAIL %s pf/irqf actual=%b%b expected=%b%b", t, pf_set, irqf_set, e, ei);
                end
            end else begin
                checks++;
                if (pf_set !== 1'b0 || irqf_set !== 1'b0) begin
                    errors++;
                    $display("FAIL R4 output without timebase pulse actual=%b%b expected=00", pf_set, irqf_set);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (pf_set !== 1'b0 || irqf_set !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b%b expected=00", pf_set, irqf_set);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R10: code 3 gives 4 pulses, div 010 is a normal value
        set_cfg(4'd3, 1'b1, 3'b010);
        pulses(12, "R1/R2 code3");
        set_cfg(4'd1, 1'b1, 3'b010);
        pulses(130, "R2 code1");
        // R3 code 0 stops and clears
        set_cfg(4'd0, 1'b1, 3'b010);
        pulses(10, "R3 code0");
        set_cfg(4'd2, 1'b1, 3'b010);
        pulses(257, "R2/R3 code2");
        // R6 enable clear
        set_cfg(4'd6, 1'b0, 3'b010);
        pulses(20, "R6 disabled");
        set_cfg(4'd6, 1'b1, 3'b010);
        pulses(33, "R6/R5 reenable");
        // R11 idle clocks between pulses
        repeat (30) @(negedge clk);
        pulses(31, "R11 gap");
        // R8 rate change keeps elapsed
        pulses(10, "R8 pre");
        set_cfg(4'd5, 1'b1, 3'b010);
        pulses(8, "R8 shorter");
        pulses(2, "R8 pre2");
        set_cfg(4'd6, 1'b1, 3'b010);
        pulses(32, "R8 longer");
        // R9 cap
        set_cfg(4'd7, 1'b1, 3'b010);
        pulses(20, "R9 pre");
        set_cfg(4'd3, 1'b1, 3'b010);
        pulses(6, "R9 capped");
        // R7 hold
        pulses(2, "R7 pre");
        set_cfg(4'd3, 1'b1, 3'b110);
        pulses(10, "R7 hold110");
        set_cfg(4'd3, 1'b1, 3'b111);
        pulses(5, "R7 hold111");
        set_cfg(4'd3, 1'b1, 3'b010);
        pulses(5, "R7 release");
        // R10 other div values
        set_cfg(4'd4, 1'b1, 3'b100);
        pulses(3, "R10 div100");
        set_cfg(4'd4, 1'b1, 3'b001);
        pulses(10, "R10 div001");
        // R2 longest period
        set_cfg(4'd15, 1'b1, 3'b000);
        pulses(16385, "R2 code15");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule